// File: doc/BRIEF.md
# Dual-Group Interrupt Merger for a Hash Engine and its Feed DMA

This block gathers event pulses from two neighbours, a hash engine and the DMA that streams input into it, and merges them into one interrupt request line. Each neighbour has its own group of registers. The hash group holds a pending-event register and an enable register. The DMA group holds the same pair plus a one-bit global unmask that must be set before any DMA event can reach the line.

Software enables the causes it cares about and waits for the line. It then reads the pending registers and writes the value it read back to the same register. That acknowledges exactly the events it saw and leaves any event that arrived later pending. Writing all ones flushes a group, and writing zero to an enable register silences that group. The register port is a plain single-cycle read/write port. Read data is registered and is returned one cycle after the read strobe.

Top module: `irq_merge_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every pending, enable and unmask bit is 0, `irq_out` is 0 and `reg_rdata` is 0.
- R2: A one-cycle pulse on an event input sets the matching pending bit at the next clock edge. Hash pending bits are read at address 0x50. There, bit 2 is the completion event and bits 0, 1 and 3 are error events. DMA pending bits are read at address 0x480. There, bit 0 is the source-transfer completion and bits 2 to 8 are seven separate error events.
- R3: A write to 0x50 or 0x480 clears each pending bit whose write-data bit is 1 and leaves every bit written 0 unchanged. Writing back a value just read clears exactly the bits in that value.
- R4: When an event pulse and a write-1-to-clear hit the same bit in the same cycle, the bit stays set.
- R5: The enable registers sit at 0x54 (hash, bits 3:0) and 0x484 (DMA, bits 8:0). They read back what was written, and writing 0 disables every source in the group.
- R6: `irq_out` is a register. One edge after a pending bit, enable bit or unmask bit changes, `irq_out` equals OR(hash pending AND hash enable) OR (unmask AND OR(DMA pending AND DMA enable)).
- R7: The unmask register at 0x488 bit 0 gates only the DMA term: 1 lets DMA events through, 0 blocks them. DMA pending bits still latch while the group is masked, and the hash term is unaffected.
- R8: DMA bit 1 is reserved. Its pending and enable bits never set and always read 0, and DMA register bits 31:9 read 0.
- R9: A read from any other address returns 0, and a write to any other address changes no register.
- R10: `reg_rdata` shows the register selected on the previous cycle when `reg_rd` was 1, and shows 0 on every cycle after one with no read. A read in the same cycle as an event returns the value held before that event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, one cycle after `reg_rd` |
| core_evt | input | 4 | Hash engine event pulses |
| dma_evt | input | 9 | DMA event pulses |
| irq_out | output | 1 | Merged interrupt request, registered |

## Verification
The hardest case to reach is an event landing on a bit in the very cycle that software acknowledges it. A plain read-then-write-back sequence never produces this collision. The bench therefore times an event pulse to coincide with the write strobe on the same bit. It also places a second event between the read and the write-back, which checks that only the observed bits are cleared. A further case is a DMA event that latches while the group is masked and only raises the line once unmask is written. That case is driven explicitly, and it is also covered by a long randomised phase that mixes events, enable changes, mask toggles and acknowledgements against the bench's own model.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  // Register offsets decoded by driver software
  localparam int unsigned OFS_CORE_PEND = 32'h050;
  localparam int unsigned OFS_CORE_EN   = 32'h054;
  localparam int unsigned OFS_DMA_PEND  = 32'h480;
  localparam int unsigned OFS_DMA_EN    = 32'h484;
  localparam int unsigned OFS_DMA_UNMSK = 32'h488;

  // One-hot register select
  typedef struct packed {
    logic core_pend;
    logic core_en;
    logic dma_pend;
    logic dma_en;
    logic dma_unmsk;
  } reg_sel_t;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_merge_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel           = '0;
    sel.core_pend = (addr == ADDR_W'(OFS_CORE_PEND));
    sel.core_en   = (addr == ADDR_W'(OFS_CORE_EN));
    sel.dma_pend  = (addr == ADDR_W'(OFS_DMA_PEND));
    sel.dma_en    = (addr == ADDR_W'(OFS_DMA_EN));
    sel.dma_unmsk = (addr == ADDR_W'(OFS_DMA_UNMSK));
  end
endmodule

// File: rtl/irq_src_group.sv
// One group of pending (write-1-to-clear) and enable bits.
module irq_src_group #(
  parameter int           W    = 4,
  parameter logic [W-1:0] IMPL = '1   // bits that exist; others tie to 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic         hit
);
  logic unused_rsvd;
  assign unused_rsvd = ^{evt & ~IMPL, wdata & ~IMPL};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst) begin
          pend[i] <= 1'b0;
          en[i]   <= 1'b0;
        end else begin
          // new event outranks a same-cycle clear
          pend[i] <= (pend[i] & ~(clr_wr & wdata[i])) | evt[i];
          if (en_wr) en[i] <= wdata[i];
        end
      end
    end else begin : g_rsvd
      assign pend[i] = 1'b0;
      assign en[i]   = 1'b0;
    end
  end

  assign hit = |(pend & en);
endmodule

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
  import irq_merge_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 32,
  parameter int                CORE_W   = 4,
  parameter int                DMA_W    = 9,
  parameter logic [DMA_W-1:0]  DMA_IMPL = 9'h1FD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CORE_W-1:0] core_evt,
  input  logic [DMA_W-1:0]  dma_evt,
  output logic              irq_out
);
  localparam logic [CORE_W-1:0] CORE_IMPL = '1;

  reg_sel_t          sel;
  logic [CORE_W-1:0] core_pend, core_en;
  logic [DMA_W-1:0]  dma_pend, dma_en;
  logic              core_hit, dma_hit, dma_unmsk;
  logic [DATA_W-1:0] rd_val;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:DMA_W];

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (reg_addr),
    .sel  (sel)
  );

  irq_src_group #(.W(CORE_W), .IMPL(CORE_IMPL)) u_core (
    .clk    (clk),
    .rst    (rst),
    .evt    (core_evt),
    .clr_wr (reg_wr & sel.core_pend),
    .en_wr  (reg_wr & sel.core_en),
    .wdata  (reg_wdata[CORE_W-1:0]),
    .pend   (core_pend),
    .en     (core_en),
    .hit    (core_hit)
  );

  irq_src_group #(.W(DMA_W), .IMPL(DMA_IMPL)) u_dma (
    .clk    (clk),
    .rst    (rst),
    .evt    (dma_evt),
    .clr_wr (reg_wr & sel.dma_pend),
    .en_wr  (reg_wr & sel.dma_en),
    .wdata  (reg_wdata[DMA_W-1:0]),
    .pend   (dma_pend),
    .en     (dma_en),
    .hit    (dma_hit)
  );

  // Global DMA unmask
  always_ff @(posedge clk) begin
    if (rst)                           dma_unmsk <= 1'b0;
    else if (reg_wr && sel.dma_unmsk)  dma_unmsk <= reg_wdata[0];
  end

  // Read mux
  always_comb begin
    rd_val = '0;
    unique case (1'b1)
      sel.core_pend: rd_val[CORE_W-1:0] = core_pend;
      sel.core_en:   rd_val[CORE_W-1:0] = core_en;
      sel.dma_pend:  rd_val[DMA_W-1:0]  = dma_pend;
      sel.dma_en:    rd_val[DMA_W-1:0]  = dma_en;
      sel.dma_unmsk: rd_val[0]          = dma_unmsk;
      default:       rd_val             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      reg_rdata <= reg_rd ? rd_val : '0;
      irq_out   <= core_hit | (dma_unmsk & dma_hit);
    end
  end
endmodule

// File: rtl/irq_merge_chk.sv
module irq_merge_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CORE_W = 4,
  parameter int DMA_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CORE_W-1:0] core_evt,
  input logic [DMA_W-1:0]  dma_evt,
  input logic [CORE_W-1:0] core_pend,
  input logic [CORE_W-1:0] core_en,
  input logic [DMA_W-1:0]  dma_pend,
  input logic [DMA_W-1:0]  dma_en,
  input logic              dma_unmsk,
  input logic              irq_out
);
  logic              rst_q;
  logic              core_clr, dma_clr;
  logic [CORE_W-1:0] core_clr_bits;
  logic [DMA_W-1:0]  dma_clr_bits;

  assign core_clr      = reg_wr && (reg_addr == ADDR_W'(12'h050));
  assign dma_clr       = reg_wr && (reg_addr == ADDR_W'(12'h480));
  assign core_clr_bits = core_clr ? reg_wdata[CORE_W-1:0] : '0;
  assign dma_clr_bits  = dma_clr  ? reg_wdata[DMA_W-1:0]  : '0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_STATE: assert (core_pend == '0 && dma_pend == '0 && core_en == '0
                               && dma_en == '0 && !dma_unmsk && !irq_out); // R1
    end
  end

  AST_CORE_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (core_evt != '0) |=> ((core_pend & $past(core_evt)) == $past(core_evt))); // R4

  AST_DMA_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    ((dma_evt & 9'h1FD) != '0) |=> ((dma_pend & $past(dma_evt & 9'h1FD)) == $past(dma_evt & 9'h1FD))); // R2

  AST_CORE_FALL_ONLY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(core_pend) & ~core_pend) & ~$past(core_clr_bits)) == '0)); // R3

  AST_DMA_FALL_ONLY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(dma_pend) & ~dma_pend) & ~$past(dma_clr_bits)) == '0)); // R3

  AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(((core_pend & core_en) != '0) ||
                                (dma_unmsk && ((dma_pend & dma_en) != '0))))); // R6

  AST_RSVD_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !dma_pend[1] && !dma_en[1]); // R8
endmodule

bind irq_merge_ctrl irq_merge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CORE_W(CORE_W), .DMA_W(DMA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .core_evt  (core_evt),
  .dma_evt   (dma_evt),
  .core_pend (core_pend),
  .core_en   (core_en),
  .dma_pend  (dma_pend),
  .dma_en    (dma_en),
  .dma_unmsk (dma_unmsk),
  .irq_out   (irq_out)
);

// File: tb/sim_irq_merge_ctrl.sv
module sim_irq_merge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  core_evt = '0;
  logic [8:0]  dma_evt = '0;
  logic        irq_out;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_merge_ctrl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_evt(core_evt), .dma_evt(dma_evt), .irq_out(irq_out)
  );

  // ---------------- behavioural reference model ----------------
  int unsigned m_cp, m_ce, m_dp, m_de, m_mk, m_rd;
  bit          m_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_cp = 0; m_ce = 0; m_dp = 0; m_de = 0; m_mk = 0; m_rd = 0; m_irq = 0;
    end else begin
      int unsigned v;
      v = 0;
      if (reg_rd) begin
        case (reg_addr)
          12'h050: v = m_cp;
          12'h054: v = m_ce;
          12'h480: v = m_dp;
          12'h484: v = m_de;
          12'h488: v = m_mk;
          default: v = 0;
        endcase
      end
      m_rd  = v;
      m_irq = ((m_cp & m_ce) != 0) || (m_mk != 0 && (m_dp & m_de) != 0);
      if (reg_wr) begin
        case (reg_addr)
          12'h050: m_cp = m_cp & ~reg_wdata;
          12'h054: m_ce = reg_wdata & 32'hF;
          12'h480: m_dp = m_dp & ~reg_wdata;
          12'h484: m_de = reg_wdata & 32'h1FD;
          12'h488: m_mk = reg_wdata & 32'h1;
          default: ;
        endcase
      end
      m_cp = (m_cp | 32'(core_evt)) & 32'hF;
      m_dp = (m_dp | 32'(dma_evt)) & 32'h1FD;
    end
  end

  task automatic chk(input string req, input int unsigned got, input int unsigned exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_req, " rdata"}, reg_rdata, m_rd);
      chk({cur_req, " irq"}, 32'(irq_out), 32'(m_irq));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input int unsigned exp, input string req);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic rd_get(input logic [11:0] a, output int unsigned val);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    val = reg_rdata;
  endtask

  task automatic pulse(input logic [3:0] c, input logic [8:0] d);
    @(negedge clk);
    core_evt = c; dma_evt = d;
    @(negedge clk);
    core_evt = '0; dma_evt = '0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    int unsigned v;
    repeat (3) @(negedge clk);
    rst = 0;

    cur_req = "R1";
    chk("R1 irq after reset", 32'(irq_out), 0);
    chk("R1 rdata after reset", reg_rdata, 0);
    rd_chk(12'h050, 0, "R1 core pend");
    rd_chk(12'h054, 0, "R1 core en");
    rd_chk(12'h480, 0, "R1 dma pend");
    rd_chk(12'h484, 0, "R1 dma en");
    rd_chk(12'h488, 0, "R1 unmask");

    cur_req = "R2";
    pulse(4'b0100, 9'h0);
    rd_chk(12'h050, 32'h4, "R2 core done bit");
    pulse(4'b1011, 9'h001);
    rd_chk(12'h050, 32'hF, "R2 core error bits");
    rd_chk(12'h480, 32'h001, "R2 dma done bit");

    cur_req = "R8";
    pulse(4'h0, 9'h1FF);
    rd_chk(12'h480, 32'h1FD, "R8 reserved pend bit");

    cur_req = "R5";
    wr(12'h054, 32'hFFFF_FFFF);
    rd_chk(12'h054, 32'hF, "R5 core en readback");
    wr(12'h484, 32'hFFFF_FFFF);
    rd_chk(12'h484, 32'h1FD, "R8 dma en reserved bit");

    cur_req = "R6";
    idle(1);
    chk("R6 irq from core", 32'(irq_out), 1);
    wr(12'h050, 32'hFFFF_FFFF);
    idle(1);
    chk("R6 irq drops after flush", 32'(irq_out), 0);

    cur_req = "R7";
    chk("R7 dma pending but masked", 32'(irq_out), 0);
    wr(12'h488, 32'h1);
    idle(1);
    chk("R7 irq after unmask", 32'(irq_out), 1);
    wr(12'h488, 32'h0);
    wr(12'h480, 32'hFFFF_FFFF);
    pulse(4'h0, 9'h010);
    idle(2);
    chk("R7 masked dma event no irq", 32'(irq_out), 0);
    rd_chk(12'h480, 32'h010, "R7 latched while masked");
    pulse(4'h2, 9'h0);
    idle(1);
    chk("R7 core term not masked", 32'(irq_out), 1);

    cur_req = "R5";
    wr(12'h054, 32'h0);
    idle(1);
    chk("R5 core disabled", 32'(irq_out), 0);
    rd_chk(12'h050, 32'h2, "R5 pend kept when disabled");

    cur_req = "R3";
    wr(12'h480, 32'hFFFF_FFFF);
    pulse(4'h0, 9'h005);
    rd_get(12'h480, v);
    chk("R3 read value", v, 32'h005);
    pulse(4'h0, 9'h100);
    wr(12'h480, v);
    rd_chk(12'h480, 32'h100, "R3 writeback clears only seen bits");
    wr(12'h050, 32'h0);
    rd_chk(12'h050, 32'h2, "R3 write of zeros keeps bits");

    cur_req = "R4";
    @(negedge clk);
    reg_wr = 1; reg_addr = 12'h050; reg_wdata = 32'hF; core_evt = 4'h8;
    @(negedge clk);
    reg_wr = 0; core_evt = '0;
    rd_chk(12'h050, 32'h8, "R4 event beats clear");

    cur_req = "R9";
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h058, 32'hFFFF_FFFF);
    rd_chk(12'h100, 0, "R9 unmapped read");
    rd_chk(12'h054, 0, "R9 enable untouched");
    rd_chk(12'h488, 0, "R9 unmask untouched");

    cur_req = "R10";
    @(negedge clk);
    reg_rd = 1; reg_addr = 12'h050; core_evt = 4'h1;
    @(negedge clk);
    reg_rd = 0; core_evt = '0;
    chk("R10 read sees pre-event value", reg_rdata, 32'h8);
    @(negedge clk);
    chk("R10 rdata zero without read", reg_rdata, 0);

    // randomised mix, model compared every cycle
    cur_req = "R6";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      core_evt = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      dma_evt  = ($urandom_range(0, 7) == 0) ? 9'($urandom) : 9'h0;
      reg_wr   = ($urandom_range(0, 3) == 0);
      reg_rd   = ($urandom_range(0, 1) == 0);
      case ($urandom_range(0, 5))
        0: reg_addr = 12'h050;
        1: reg_addr = 12'h054;
        2: reg_addr = 12'h480;
        3: reg_addr = 12'h484;
        4: reg_addr = 12'h488;
        default: reg_addr = 12'h0F0;
      endcase
      reg_wdata = $urandom;
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; core_evt = '0; dma_evt = '0;
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule